// File: doc/BRIEF.md
# Serial Unlock Key Detector for a Memory-Socket Timekeeper

This block sits beside a memory socket and watches its bus cycles, each presented as a single-cycle read strobe or write strobe. On writes it also sees the least significant data line. A timekeeper hidden behind the memory stays invisible until software sends a fixed 64-bit unlock key, one bit per write, after first arming the detector with any read. Until the key has fully matched, every cycle, including the key writes, reaches memory as normal.

Once all 64 key bits match in a row, the block opens a transfer window for the next 64 strobed cycles. During the window it inhibits memory, reports a bit index from 0 to 63 and flags each cycle as a shift-out (read) or shift-in (write) for the timekeeper's serial port. A read during recognition rearms the pointer at bit 0. A wrong bit freezes recognition until the next read. An enabled external abort input, or the synchronous reset, drops the block back to idle.

Top module: `unlock_seq_det`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge) mem_inhibit, xfer_active, xfer_rd, xfer_wr are 0 and xfer_idx is 0. The block is idle and unarmed.
- R2: The key bit for write number i (i = 0..63) is bit (i mod 8) of byte floor(i/8) of the byte sequence C5, 3A, A3, 5C, C5, 3A, A3, 5C, so the key is the 64-bit value 5CA33AC55CA33AC5 read from bit 0 upward. After an arming read, 64 consecutive writes whose dq0 match the key set xfer_active and mem_inhibit in the cycle after the 64th write strobe, with xfer_idx at 0.
- R3: A read strobe during recognition returns the key pointer to bit 0. A full key sent after that read unlocks, whatever partial key came before the read.
- R4: A write whose dq0 differs from the expected key bit freezes recognition. Later writes, even ones that would continue the key correctly, do not unlock until a read rearms the detector.
- R5: Before the 64-bit match completes, mem_inhibit stays 0 on every cycle, including the 64th key write itself.
- R6: In the transfer window mem_inhibit is 1. xfer_idx equals the number of strobed cycles already taken in the window, advances by one per read or write strobe, and holds on cycles without a strobe.
- R7: xfer_rd is 1 exactly when a read strobe occurs in the transfer window, and xfer_wr is 1 exactly when a write strobe occurs in it. Both are 0 outside the window.
- R8: After the 64th transfer strobe the block returns to idle (xfer_active 0, xfer_idx 0). From idle, writes without a preceding read are ignored, so a full key alone does not unlock.
- R9: When ext_rst_en is 1 and ext_rst_n is 0 at a clock edge, the block returns to idle and a transfer in progress ends. With ext_rst_en at 0, ext_rst_n has no effect.
- R10: A synchronous reset during a transfer returns the block to idle with no partial state left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_stb | input | 1 | One-cycle strobe marking a read cycle |
| wr_stb | input | 1 | One-cycle strobe marking a write cycle |
| wr_dq0 | input | 1 | Data bit 0 of the write cycle |
| ext_rst_n | input | 1 | External abort request, active low |
| ext_rst_en | input | 1 | Allows ext_rst_n to abort |
| mem_inhibit | output | 1 | Memory access blocked for the current cycle |
| xfer_active | output | 1 | Transfer window open |
| xfer_idx | output | 6 | Bit index of the next transfer cycle |
| xfer_rd | output | 1 | Current cycle shifts a bit out of the timekeeper |
| xfer_wr | output | 1 | Current cycle shifts a bit into the timekeeper |

## Verification
The assertions assume that a read strobe and a write strobe never occur in the same cycle, and that strobes last a single clock. The bench keeps to both by driving every bus cycle through one task that raises exactly one strobe for one clock and then clears it. The same task can insert strobe-free cycles, which exercise the hold behaviour of the index. Abort and reset are changed only between bus cycles, so each check sees one well-defined cause.

// File: rtl/unlock_pkg.sv
package unlock_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2,
    ST_XFER = 2'd3
  } unl_state_t;

  // Key bit for write number idx: four distinct bytes repeat, each LSB first.
  function automatic logic key_bit(input int unsigned idx);
    logic [7:0] kb;
    case ((idx / 8) % 4)
      0:       kb = 8'hC5;
      1:       kb = 8'h3A;
      2:       kb = 8'hA3;
      default: kb = 8'h5C;
    endcase
    return kb[idx % 8];
  endfunction

endpackage

// File: rtl/unlock_key_match.sv
module unlock_key_match #(
  parameter int KEY_BITS = 64,
  localparam int PW = $clog2(KEY_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          dq0,
  output logic [PW-1:0] ptr,
  output logic          hit,
  output logic          last
);
  import unlock_pkg::*;

  assign hit  = (dq0 == key_bit(int'(ptr)));
  assign last = (ptr == PW'(KEY_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      ptr <= '0;
    else if (adv)
      ptr <= last ? '0 : ptr + 1'b1;
  end
endmodule

// File: rtl/unlock_xfer_ctr.sv
module unlock_xfer_ctr #(
  parameter int XFER_BITS = 64,
  localparam int IW = $clog2(XFER_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [IW-1:0] idx,
  output logic          last
);
  assign last = (idx == IW'(XFER_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr)
      idx <= '0;
    else if (adv)
      idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/unlock_seq_det.sv
module unlock_seq_det #(
  parameter int KEY_BITS  = 64,
  parameter int XFER_BITS = 64,
  localparam int PW = $clog2(KEY_BITS),
  localparam int IW = $clog2(XFER_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic          wr_dq0,
  input  logic          ext_rst_n,
  input  logic          ext_rst_en,
  output logic          mem_inhibit,
  output logic          xfer_active,
  output logic [IW-1:0] xfer_idx,
  output logic          xfer_rd,
  output logic          xfer_wr
);
  import unlock_pkg::*;

  unl_state_t state_q, state_d;

  // Named internal events for the checker
  logic          abort_w;
  logic          in_xfer_w;
  logic          hunt_wr_w;
  logic          key_hit_w;
  logic          key_last_w;
  logic          key_done_w;
  logic          xfer_stb_w;
  logic          xfer_last_w;
  logic          xfer_done_w;
  logic          locked_w;
  logic [PW-1:0] key_ptr;

  assign abort_w     = ext_rst_en & ~ext_rst_n;
  assign in_xfer_w   = (state_q == ST_XFER);
  assign locked_w    = (state_q == ST_LOCK);
  assign hunt_wr_w   = (state_q == ST_HUNT) & wr_stb & ~rd_stb & ~abort_w;
  assign key_done_w  = hunt_wr_w & key_hit_w & key_last_w;
  assign xfer_stb_w  = in_xfer_w & (rd_stb | wr_stb) & ~abort_w;
  assign xfer_done_w = xfer_stb_w & xfer_last_w;

  unlock_key_match #(.KEY_BITS(KEY_BITS)) u_match (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (abort_w | (rd_stb & ~in_xfer_w)),
    .adv  (hunt_wr_w & key_hit_w),
    .dq0  (wr_dq0),
    .ptr  (key_ptr),
    .hit  (key_hit_w),
    .last (key_last_w)
  );

  unlock_xfer_ctr #(.XFER_BITS(XFER_BITS)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (abort_w),
    .adv  (xfer_stb_w),
    .idx  (xfer_idx),
    .last (xfer_last_w)
  );

  always_comb begin
    state_d = state_q;
    if (abort_w) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (rd_stb) state_d = ST_HUNT;
        ST_HUNT: begin
          if (rd_stb)
            state_d = ST_HUNT;
          else if (wr_stb)
            state_d = !key_hit_w ? ST_LOCK : (key_last_w ? ST_XFER : ST_HUNT);
        end
        ST_LOCK: if (rd_stb) state_d = ST_HUNT;
        ST_XFER: if (xfer_done_w) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign xfer_active = in_xfer_w;
  assign mem_inhibit = in_xfer_w;
  assign xfer_rd     = in_xfer_w & rd_stb;
  assign xfer_wr     = in_xfer_w & wr_stb & ~rd_stb;

endmodule

// File: rtl/unlock_seq_chk.sv
module unlock_seq_chk #(
  parameter int PW = 6,
  parameter int IW = 6,
  parameter int XFER_BITS = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic          abort_w,
  input logic          key_done_w,
  input logic          locked_w,
  input logic [PW-1:0] key_ptr,
  input logic          mem_inhibit,
  input logic          xfer_active,
  input logic [IW-1:0] xfer_idx,
  input logic          xfer_rd,
  input logic          xfer_wr
);

  // R2: the window opens only right after the final key bit matched
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |-> ($past(key_done_w) && xfer_idx == '0));

  // R3: a read outside the window puts the key pointer back at bit 0
  a_r3_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !xfer_active) |=> (key_ptr == '0));

  // R4: a frozen detector keeps its pointer until a read or abort
  a_r4_frozen_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_w && !rd_stb && !abort_w) |=> $stable(key_ptr));

  // R6: each strobe in the window advances the index by one
  a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && (rd_stb || wr_stb) && !abort_w && xfer_idx != IW'(XFER_BITS - 1))
      |=> (xfer_idx == $past(xfer_idx) + 1'b1));

  // R6: index holds on cycles without a strobe
  a_r6_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && !rd_stb && !wr_stb && !abort_w) |=> $stable(xfer_idx));

  // R7: direction flags never overlap and stay low outside the window
  a_r7_dir_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({xfer_rd, xfer_wr}) && (!mem_inhibit -> !(xfer_rd || xfer_wr)));

  // R8: the last transfer strobe closes the window
  a_r8_close: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_active && (rd_stb || wr_stb) && xfer_idx == IW'(XFER_BITS - 1))
      |=> !xfer_active);

  // R9: an enabled abort leaves the block idle
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (!xfer_active && xfer_idx == '0 && key_ptr == '0));

endmodule

bind unlock_seq_det unlock_seq_chk #(.PW(PW), .IW(IW), .XFER_BITS(XFER_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .abort_w    (abort_w),
  .key_done_w (key_done_w),
  .locked_w   (locked_w),
  .key_ptr    (key_ptr),
  .mem_inhibit(mem_inhibit),
  .xfer_active(xfer_active),
  .xfer_idx   (xfer_idx),
  .xfer_rd    (xfer_rd),
  .xfer_wr    (xfer_wr)
);

// File: tb/unlock_seq_det_tb.sv
module unlock_seq_det_tb;
  localparam logic [63:0] KEY = 64'h5CA33AC55CA33AC5;

  logic clk = 0, rst_n = 0, rd_stb = 0, wr_stb = 0, wr_dq0 = 0;
  logic ext_rst_n = 1, ext_rst_en = 0;
  logic mem_inhibit, xfer_active, xfer_rd, xfer_wr;
  logic [5:0] xfer_idx;
  logic c_inh, c_xrd, c_xwr;
  logic [5:0] c_idx;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  unlock_seq_det u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_dq0(wr_dq0),
    .ext_rst_n(ext_rst_n), .ext_rst_en(ext_rst_en), .mem_inhibit(mem_inhibit),
    .xfer_active(xfer_active), .xfer_idx(xfer_idx), .xfer_rd(xfer_rd), .xfer_wr(xfer_wr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One bus cycle, called at a negedge; combinational outputs sampled mid-cycle.
  task automatic cycle(input logic r, input logic w, input logic d);
    rd_stb = r; wr_stb = w; wr_dq0 = d;
    #2;
    c_inh = mem_inhibit; c_xrd = xfer_rd; c_xwr = xfer_wr; c_idx = xfer_idx;
    @(posedge clk); @(negedge clk);
    rd_stb = 0; wr_stb = 0; wr_dq0 = 0;
  endtask

  task automatic send_key(input int from, input int upto, input int flip);
    for (int i = from; i <= upto; i++) begin
      cycle(1'b0, 1'b1, KEY[i] ^ (i == flip));
      chk("R5 no inhibit during key", c_inh, 0);
      chk("R7 no shift-in before unlock", c_xwr, 0);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 inhibit", mem_inhibit, 0);
    chk("R1 active", xfer_active, 0);
    chk("R1 idx", xfer_idx, 0);
    chk("R1 dir", {xfer_rd, xfer_wr}, 0);
  endtask

  task automatic t_unlock_and_transfer();
    cycle(1'b1, 1'b0, 1'b0);
    chk("R7 arming read not a shift", c_xrd, 0);
    send_key(0, 62, -1);
    chk("R2 not open before last bit", xfer_active, 0);
    send_key(63, 63, -1);
    chk("R2 window open", xfer_active, 1);
    chk("R2 idx zero", xfer_idx, 0);
    for (int k = 0; k < 64; k++) begin
      logic r;
      r = (k % 3 == 0);
      cycle(r, !r, k[0]);
      chk("R6 inhibit in window", c_inh, 1);
      chk("R6 idx", c_idx, k);
      chk("R7 shift-out flag", c_xrd, r);
      chk("R7 shift-in flag", c_xwr, !r);
      if (k == 20) begin
        cycle(1'b0, 1'b0, 1'b0);
        chk("R6 idx holds without strobe", c_idx, 21);
      end
    end
    chk("R8 idle after 64", xfer_active, 0);
    chk("R8 idx cleared", xfer_idx, 0);
    send_key(0, 63, -1);
    chk("R8 key without read ignored", xfer_active, 0);
  endtask

  task automatic t_reread_and_abort();
    cycle(1'b1, 1'b0, 1'b0);
    send_key(0, 29, -1);
    cycle(1'b1, 1'b0, 1'b0);
    send_key(0, 63, -1);
    chk("R3 unlock after rearm", xfer_active, 1);
    cycle(1'b1, 1'b0, 1'b0);
    cycle(1'b0, 1'b1, 1'b1);
    chk("R6 idx after two", xfer_idx, 2);
    ext_rst_en = 1; ext_rst_n = 0;
    @(negedge clk);
    ext_rst_n = 1; ext_rst_en = 0;
    chk("R9 abort closes window", xfer_active, 0);
    chk("R9 abort clears idx", xfer_idx, 0);
  endtask

  task automatic t_mismatch_and_reset();
    cycle(1'b1, 1'b0, 1'b0);
    send_key(0, 63, 10);
    chk("R4 mismatch freezes", xfer_active, 0);
    send_key(10, 63, -1);
    chk("R4 retry without read ignored", xfer_active, 0);
    cycle(1'b1, 1'b0, 1'b0);
    send_key(0, 63, -1);
    chk("R4 unlock after read", xfer_active, 1);
    ext_rst_en = 0; ext_rst_n = 0;
    cycle(1'b0, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 1'b0);
    chk("R9 disabled abort ignored", xfer_active, 1);
    chk("R9 idx kept counting", xfer_idx, 2);
    ext_rst_n = 1;
    cycle(1'b0, 1'b1, 1'b0);
    do_reset();
    chk("R10 reset closes window", xfer_active, 0);
    chk("R10 idx cleared", xfer_idx, 0);
    send_key(0, 63, -1);
    chk("R10 no arm left after reset", xfer_active, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_unlock_and_transfer();
    t_reread_and_abort();
    t_mismatch_and_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule